// File: doc/BRIEF.md
# Four-Way Structure De-Interleaver

This block takes a run of interleaved four-component records, such as RGBA pixels, as they arrive from a memory read port. It transposes them into four destination vector registers. Register `vd+k` collects component k of every record, and the records occupy its lanes in order. A load is launched with a base address, an element size, a first destination register number and a writeback choice. The block then draws 64-bit little-endian beats over a valid/ready handshake until the whole block of records has arrived. After that it commits all four register writes in a single cycle.

The block holds the four register images in staging storage. A stall in the middle of a load therefore never produces a partial write. When the load ends, the block reports the new base address. With writeback on, that address is the old base plus the size of the whole structure block. With writeback off, it is the old base. The block has no path to condition flags, so it cannot disturb them.

Top module: `deint4`

## Requirements
- R1: While reset is high and after it falls, `busy`, `done`, `wr_en` and `beat_ready` are 0 and `base_out` is 0.
- R2: A `start` seen while `busy` is 0 captures `base_in`, `esize_in`, `vd_in` and `wb_in` and sets `busy`. A `start` seen while `busy` is 1 is ignored and does not alter the load in progress.
- R3: `esize_in` encodes the element width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, and 3 acts as 32-bit. A load consumes 4, 8 or 16 beats for 8-, 16- or 32-bit elements. `beat_ready` equals `busy`. `done` is a one-cycle pulse in the cycle after the last beat is accepted, and `busy` falls at the same time.
- R4: Record i, component k (k = 0..3) is written to lane i of register `wr_reg_k = (vd + k) mod 32`. Register numbers wrap past 31.
- R5: The block treats the incoming stream as bytes at offsets 0, 1, 2 and so on from the base. Beat n carries offsets 8n..8n+7, with offset 8n+j in bits [8j+7:8j]. Record i starts at offset 4·i·E, where E is the element byte count. Component k of a record sits at offset 4·i·E + k·E and is little-endian.
- R6: Each register holds 8 lanes. Lane i occupies bits [8E·i + 8E−1 : 8E·i]. All bits above 64·E are 0.
- R7: At the `done` cycle, `base_out` becomes base + 32·E if writeback was requested, and base otherwise. It holds its value at all other times.
- R8: `wr_en` is high only in the `done` cycle. Stall cycles (`beat_valid` low) neither advance the load nor cause any write.
- R9: While `busy`, `mem_addr` equals base + 8 × (number of beats accepted so far).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a load when idle |
| base_in | input | 32 | Base byte address of the record block |
| esize_in | input | 2 | Element width code |
| vd_in | input | 5 | First destination register number |
| wb_in | input | 1 | Request base post-increment |
| beat_valid | input | 1 | Memory beat present |
| beat_data | input | 64 | Memory beat, little-endian bytes |
| beat_ready | output | 1 | Block accepts a beat this cycle |
| mem_addr | output | 32 | Byte address of the beat expected next |
| wr_en | output | 1 | Commit all four register writes |
| wr_reg0 | output | 5 | Register number for component 0 |
| wr_reg1 | output | 5 | Register number for component 1 |
| wr_reg2 | output | 5 | Register number for component 2 |
| wr_reg3 | output | 5 | Register number for component 3 |
| wr_data0 | output | 256 | Lanes for component 0 |
| wr_data1 | output | 256 | Lanes for component 1 |
| wr_data2 | output | 256 | Lanes for component 2 |
| wr_data3 | output | 256 | Lanes for component 3 |
| base_out | output | 32 | Updated base address |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a long stall in the middle of a load while a fresh `start` with different parameters arrives. To cover it, the stimulus withholds `beat_valid` at random for many cycles. In chosen runs it also pulses `start` after the first beat has been accepted. The committed registers, register numbers and base must still match the original parameters. Patterned memory gives every byte a distinct value, so a single misplaced byte shows up in every element width.

// File: rtl/deint_pkg.sv
package deint_pkg;

    localparam int REGN_W = 5;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_B16 = 2'd1,
        ESZ_B32 = 2'd2,
        ESZ_RSV = 2'd3
    } esz_e;

    typedef struct packed {
        logic [1:0]        sh;   // log2 of element bytes
        logic              wb;
        logic [REGN_W-1:0] vd;
    } op_cfg_t;

    // log2 of the element byte count; the reserved code behaves as 32-bit
    function automatic logic [1:0] esz_shift(input esz_e e);
        return (e == ESZ_RSV) ? 2'd2 : 2'(e);
    endfunction

endpackage

// File: rtl/deint_ctrl.sv
module deint_ctrl #(
    parameter int ELEMS      = 8,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [1:0]       sh,
    input  logic             beat_valid,
    output logic             busy,
    output logic             hs,
    output logic             last,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam int BB_LG = $clog2(BEAT_BYTES);

    logic [CNT_W+3:0] total;

    always_comb begin
        total = ((CNT_W+4)'(4 * ELEMS) << sh) >> BB_LG;
        hs    = busy & beat_valid;
        last  = ({4'd0, cnt} == total - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (hs) begin
                cnt <= cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r3_done_after_beat: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(hs) && !busy));
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_valid) |=> $stable(cnt));

endmodule

// File: rtl/deint_scatter.sv
module deint_scatter #(
    parameter int ELEMS      = 8,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 5,
    parameter int REG_W      = ELEMS * 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       hs,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [1:0]                 sh,
    input  logic [8*BEAT_BYTES-1:0]    beat_data,
    output logic [3:0][REG_W-1:0]      stage
);
    localparam int BB_LG = $clog2(BEAT_BYTES);
    localparam int OW    = CNT_W + BB_LG;
    localparam int DW    = $clog2(REG_W);

    logic [1:0]    dcomp [BEAT_BYTES];
    logic [DW-1:0] dbit  [BEAT_BYTES];

    // Map every byte of the beat to its component and bit position
    generate
        for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_map
            logic [OW-1:0] off;
            logic [OW-1:0] elem;
            logic [OW-1:0] sub;
            always_comb begin
                off      = {cnt, BB_LG'(k)};
                elem     = off >> sh;
                sub      = off & ((OW'(1) << sh) - 1'b1);
                dcomp[k] = elem[1:0];
                dbit[k]  = DW'((((elem >> 2) << sh) + sub) << 3);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stage <= '0;
        end else if (hs) begin
            for (int k = 0; k < BEAT_BYTES; k++) begin
                stage[dcomp[k]][dbit[k] +: 8] <= beat_data[8*k +: 8];
            end
        end
    end

    a_r8_stage_hold: assert property (@(posedge clk) disable iff (rst)
        (!hs && !clear) |=> $stable(stage));

endmodule

// File: rtl/deint4.sv
module deint4 #(
    parameter int ELEMS      = 8,
    parameter int BEAT_BYTES = 8,
    parameter int AW         = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [AW-1:0]           base_in,
    input  logic [1:0]              esize_in,
    input  logic [4:0]              vd_in,
    input  logic                    wb_in,
    input  logic                    beat_valid,
    input  logic [8*BEAT_BYTES-1:0] beat_data,
    output logic                    beat_ready,
    output logic [AW-1:0]           mem_addr,
    output logic                    wr_en,
    output logic [4:0]              wr_reg0,
    output logic [4:0]              wr_reg1,
    output logic [4:0]              wr_reg2,
    output logic [4:0]              wr_reg3,
    output logic [ELEMS*32-1:0]     wr_data0,
    output logic [ELEMS*32-1:0]     wr_data1,
    output logic [ELEMS*32-1:0]     wr_data2,
    output logic [ELEMS*32-1:0]     wr_data3,
    output logic [AW-1:0]           base_out,
    output logic                    busy,
    output logic                    done
);
    import deint_pkg::*;

    localparam int REG_W = ELEMS * 32;
    localparam int BB_LG = $clog2(BEAT_BYTES);
    localparam int CNT_W = $clog2(4 * ELEMS * 4 / BEAT_BYTES) + 1;

    op_cfg_t               cfg_q;
    logic [AW-1:0]         base_q;
    logic                  go, hs, last;
    logic [CNT_W-1:0]      cnt;
    logic [3:0][REG_W-1:0] stage;

    assign go = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (go) begin
            cfg_q  <= '{sh: esz_shift(esz_e'(esize_in)), wb: wb_in, vd: vd_in};
            base_q <= base_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_out <= '0;
        end else if (hs && last) begin
            base_out <= cfg_q.wb ? base_q + (AW'(4 * ELEMS) << cfg_q.sh) : base_q;
        end
    end

    deint_ctrl #(.ELEMS(ELEMS), .BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .go(go), .sh(cfg_q.sh), .beat_valid(beat_valid),
        .busy(busy), .hs(hs), .last(last), .cnt(cnt), .done(done)
    );

    deint_scatter #(.ELEMS(ELEMS), .BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W), .REG_W(REG_W)) u_scat (
        .clk(clk), .rst(rst), .clear(go), .hs(hs), .cnt(cnt), .sh(cfg_q.sh),
        .beat_data(beat_data), .stage(stage)
    );

    assign beat_ready = busy;
    assign mem_addr   = base_q + (AW'(cnt) << BB_LG);
    assign wr_en      = done;
    assign wr_reg0    = cfg_q.vd;
    assign wr_reg1    = cfg_q.vd + 5'd1;
    assign wr_reg2    = cfg_q.vd + 5'd2;
    assign wr_reg3    = cfg_q.vd + 5'd3;
    assign wr_data0   = stage[0];
    assign wr_data1   = stage[1];
    assign wr_data2   = stage[2];
    assign wr_data3   = stage[3];

    a_r8_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_en);
    a_r7_base_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(base_out));
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(base_q)));

endmodule

// File: tb/deint4_test.sv
module deint4_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [31:0]  base_in;
    logic [1:0]   esize_in;
    logic [4:0]   vd_in;
    logic         wb_in;
    logic         beat_valid;
    logic [63:0]  beat_data;
    logic         beat_ready;
    logic [31:0]  mem_addr;
    logic         wr_en;
    logic [4:0]   wr_reg0, wr_reg1, wr_reg2, wr_reg3;
    logic [255:0] wr_data0, wr_data1, wr_data2, wr_data3;
    logic [31:0]  base_out;
    logic         busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] blk [0:127];

    always #5 clk = ~clk;

    deint4 uut (
        .clk(clk), .rst(rst), .start(start), .base_in(base_in), .esize_in(esize_in),
        .vd_in(vd_in), .wb_in(wb_in), .beat_valid(beat_valid), .beat_data(beat_data),
        .beat_ready(beat_ready), .mem_addr(mem_addr), .wr_en(wr_en),
        .wr_reg0(wr_reg0), .wr_reg1(wr_reg1), .wr_reg2(wr_reg2), .wr_reg3(wr_reg3),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_data2(wr_data2), .wr_data3(wr_data3),
        .base_out(base_out), .busy(busy), .done(done)
    );

    task automatic check(input logic ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_reg(input int k, input int eb);
        logic [255:0] r = '0;
        for (int i = 0; i < 8; i++)
            for (int b = 0; b < eb; b++)
                r[(i*eb+b)*8 +: 8] = blk[(4*i+k)*eb + b];
        return r;
    endfunction

    function automatic logic [63:0] beat_of(input int n);
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[j*8 +: 8] = blk[n*8 + j];
        return d;
    endfunction

    task automatic run_op(input logic [31:0] base, input logic [1:0] esz, input logic [4:0] vd,
                          input logic wb, input int stall, input logic inj, input logic patterned);
        int eb, nb, n;
        logic addr_bad, early, injected, v;
        eb = (esz == 2'd0) ? 1 : (esz == 2'd1) ? 2 : 4;
        nb = 4 * eb;
        for (int i = 0; i < 128; i++) blk[i] = patterned ? 8'(i * 7 + 3) : 8'($urandom);
        @(negedge clk);
        start = 1'b1; base_in = base; esize_in = esz; vd_in = vd; wb_in = wb;
        @(negedge clk);
        n = 0; addr_bad = 0; early = 0; injected = 0;
        while (n < nb) begin
            v = ($urandom % 100) >= stall;
            beat_valid = v;
            beat_data  = beat_of(n);
            if (beat_ready && mem_addr != base + 32'(8*n)) addr_bad = 1;
            if (!beat_ready || wr_en) early = 1;
            if (inj && n == 1 && !injected) begin
                start = 1'b1; base_in = ~base; esize_in = esz ^ 2'd1;
                vd_in = vd + 5'd9; wb_in = ~wb; injected = 1;
            end else begin
                start = 1'b0;
            end
            if (v && beat_ready) n++;
            @(negedge clk);
        end
        beat_valid = 1'b0; start = 1'b0;
        check(!addr_bad, "R9 mem_addr tracks beats", 256'(addr_bad), 256'(0));
        check(!early, "R8 no write and ready held during load", 256'(early), 256'(0));
        check(done && wr_en && !busy, "R3 done one cycle after last beat",
              256'({done, wr_en, busy}), 256'(3'b110));
        check(wr_data0 == exp_reg(0, eb), "R4 R5 R6 component 0", wr_data0, exp_reg(0, eb));
        check(wr_data1 == exp_reg(1, eb), "R4 R5 R6 component 1", wr_data1, exp_reg(1, eb));
        check(wr_data2 == exp_reg(2, eb), "R4 R5 R6 component 2", wr_data2, exp_reg(2, eb));
        check(wr_data3 == exp_reg(3, eb), "R4 R5 R6 component 3", wr_data3, exp_reg(3, eb));
        check({wr_reg0, wr_reg1, wr_reg2, wr_reg3} == {vd, vd + 5'd1, vd + 5'd2, vd + 5'd3},
              "R4 register numbers", 256'({wr_reg0, wr_reg1, wr_reg2, wr_reg3}),
              256'({vd, vd + 5'd1, vd + 5'd2, vd + 5'd3}));
        check(base_out == (wb ? base + 32'(32*eb) : base), "R7 base update",
              256'(base_out), 256'(wb ? base + 32'(32*eb) : base));
        @(negedge clk);
        check(!done && !wr_en, "R3 R8 done is a single pulse", 256'({done, wr_en}), 256'(0));
        check(base_out == (wb ? base + 32'(32*eb) : base), "R7 base holds",
              256'(base_out), 256'(wb ? base + 32'(32*eb) : base));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; base_in = '0; esize_in = '0; vd_in = '0; wb_in = 1'b0;
        beat_valid = 1'b0; beat_data = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_en && !beat_ready && base_out == 0, "R1 reset state",
              256'({busy, done, wr_en, beat_ready, base_out}), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wr_en && !beat_ready && base_out == 0, "R1 idle after reset",
              256'({busy, done, wr_en, beat_ready, base_out}), 256'(0));
        // directed: each element size, writeback on and off
        run_op(32'h1000, 2'd0, 5'd4,  1'b1, 0,  1'b0, 1'b1);
        run_op(32'h2000, 2'd1, 5'd8,  1'b0, 0,  1'b0, 1'b1);
        run_op(32'h3000, 2'd2, 5'd12, 1'b1, 0,  1'b0, 1'b1);
        // R3 reserved code acts as 32-bit; R4 register wrap
        run_op(32'h4000, 2'd3, 5'd30, 1'b1, 30, 1'b0, 1'b1);
        // R2 start during a stalled load is ignored
        run_op(32'h5000, 2'd0, 5'd1,  1'b1, 70, 1'b1, 1'b0);
        run_op(32'h6000, 2'd2, 5'd29, 1'b0, 80, 1'b1, 1'b0);
        // R8 heavy stalls
        run_op(32'hFFFF_FF80, 2'd1, 5'd31, 1'b1, 90, 1'b0, 1'b0);
        for (int t = 0; t < 24; t++)
            run_op($urandom, 2'($urandom % 4), 5'($urandom), 1'($urandom), int'($urandom % 60),
                   1'($urandom), 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule